// File: doc/BRIEF.md
# Shared Work-RAM Ownership Switch

This block sits between a word-wide shared RAM and three requesters: a main CPU, a sub CPU and a graphics coprocessor. The RAM is built as two physical halves. A small control register picks how those halves appear. In the "whole" arrangement they form one linear 256 KB space that belongs to a single CPU at a time. In the "split" arrangement each CPU gets one 128 KB half, and a single bit chooses which half goes to which CPU.

Each CPU presents a byte address on its own bus. The block checks that address against that CPU's window for the current arrangement. It then decides whether the CPU may touch the RAM and steers the access to the correct physical half. A request inside the window that is refused reads back zero, loses its write and raises a one-cycle violation flag. The coprocessor uses a linear offset into the whole RAM. It is served only while its enable bit is set, and only on a half that no CPU is using in that cycle.

A control write is held back until a cycle in which neither CPU is requesting. An access in flight therefore always finishes under the mapping it started with. The depth of each modelled half is a parameter. Offset bits above the modelled depth alias onto the stored words.

Top module: `shram_switch`

## Requirements
- R1: After reset the arrangement is whole, the main CPU owns the RAM and the coprocessor is disabled. With the default region setting, `ctl_rdata` reads 0x03.
- R2: In whole arrangement the main CPU window is 0x200000 to 0x23FFFF. Byte offset bit 17 picks the physical half (0 gives half 0, 1 gives half 1), and offset bits [WAW:1] pick the word. Read data appears on `main_rdata` in the cycle after the request.
- R3: In whole arrangement the sub CPU window is 0x080000 to 0x0BFFFF, with the same offset-to-half rule as R2.
- R4: In whole arrangement control bit 0 = 1 gives the RAM to the main CPU and 0 gives it to the sub CPU. A request from the non-owner inside its window reads 0x0000, writes nothing, and raises its `*_viol` output for exactly the following cycle.
- R5: In split arrangement (control bit 2 = 1) the main CPU window is 0x200000 to 0x21FFFF and the sub CPU window is 0x0C0000 to 0x0DFFFF.
- R6: In split arrangement control bit 0 = 1 maps the sub CPU to half 1 and the main CPU to half 0. Bit 0 = 0 maps the sub CPU to half 0 and the main CPU to half 1. Neither CPU is ever refused in split arrangement.
- R7: A CPU request outside its current window reaches no RAM, reads 0x0000 and raises no violation.
- R8: A control write takes effect at the end of the first cycle, after the write cycle, in which neither CPU requests. Requests made before that cycle use the old mapping.
- R9: The coprocessor is granted (`gfx_gnt`, in the same cycle) only while control bit 3 is set, and only when no CPU access targets the same physical half in that cycle. A `gfx_start` pulse sets bit 3 at the next edge. Granted read data appears on `gfx_rdata` one cycle later. Coprocessor offset bit 17 picks the half.
- R10: `ctl_rdata` shows bit 0 = swap/owner, bit 1 = REGION parameter (writes to it are ignored), bit 2 = split, bit 3 = coprocessor enable, and bits 7:4 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| main_req | input | 1 | Main CPU access request, one cycle per access |
| main_we | input | 1 | Main CPU write strobe |
| main_addr | input | 24 | Main CPU byte address |
| main_wdata | input | 16 | Main CPU write data |
| main_rdata | output | 16 | Main CPU read data, one cycle after request |
| main_viol | output | 1 | Main CPU refused-access pulse |
| sub_req | input | 1 | Sub CPU access request |
| sub_we | input | 1 | Sub CPU write strobe |
| sub_addr | input | 20 | Sub CPU byte address |
| sub_wdata | input | 16 | Sub CPU write data |
| sub_rdata | output | 16 | Sub CPU read data, one cycle after request |
| sub_viol | output | 1 | Sub CPU refused-access pulse |
| gfx_start | input | 1 | Coprocessor operation start, sets the enable bit |
| gfx_req | input | 1 | Coprocessor access request |
| gfx_we | input | 1 | Coprocessor write strobe |
| gfx_addr | input | 18 | Coprocessor byte offset into the whole RAM |
| gfx_wdata | input | 16 | Coprocessor write data |
| gfx_gnt | output | 1 | Coprocessor access accepted this cycle |
| gfx_rdata | output | 16 | Coprocessor read data, one cycle after grant |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Current applied control value |

## Verification
A wrong applied mode or swap bit shows up on the very next CPU read. Data written through one window then comes back from the wrong window or the wrong half, or a refused access raises a violation where none is due. The bench writes distinct words into both halves through one arrangement and reads them back through every other arrangement, so any swap of halves or window edge error shows within one read latency. A control update applied too early shows in the deferred-write scenario: a read held across the write returns the other half's word. The coprocessor grant is checked in the same cycle as the request, so a priority error appears immediately.

// File: rtl/shram_pkg.sv
package shram_pkg;

  typedef struct packed {
    logic gfx_en;
    logic split;
    logic swap;
  } shram_cfg_t;

  localparam int unsigned WHOLE_SPAN = 18;
  localparam int unsigned SPLIT_SPAN = 17;

  function automatic logic win_hit(input logic [23:0] a, input logic [23:0] base,
                                   input int unsigned span);
    return (a >> span) == (base >> span);
  endfunction

  function automatic logic cpu_bank(input logic is_main, input logic split,
                                    input logic swap, input logic off17);
    if (split) return is_main ? ~swap : swap;
    return off17;
  endfunction

  function automatic logic cpu_owns(input logic is_main, input logic split,
                                    input logic swap);
    if (split) return 1'b1;
    return is_main ? swap : ~swap;
  endfunction

  function automatic logic [7:0] ctl_view(input shram_cfg_t c, input logic region);
    return {4'b0000, c.gfx_en, c.split, region, c.swap};
  endfunction

endpackage

// File: rtl/shram_ctl.sv
module shram_ctl
  import shram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  input  logic       busy,
  input  logic       gfx_start,
  output shram_cfg_t cfg,
  output logic       apply_evt
);

  shram_cfg_t pend;
  logic       pend_vld;
  logic       unused_wbits;

  assign unused_wbits = ^{ctl_wdata[7:4], ctl_wdata[1]};
  assign apply_evt    = pend_vld && !ctl_we && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg      <= '{gfx_en: 1'b0, split: 1'b0, swap: 1'b1};
      pend     <= '{gfx_en: 1'b0, split: 1'b0, swap: 1'b1};
      pend_vld <= 1'b0;
    end else begin
      if (ctl_we) begin
        pend     <= '{gfx_en: ctl_wdata[3], split: ctl_wdata[2], swap: ctl_wdata[0]};
        pend_vld <= 1'b1;
      end else if (apply_evt) begin
        cfg      <= pend;
        pend_vld <= 1'b0;
      end
      if (gfx_start) begin
        cfg.gfx_en  <= 1'b1;
        pend.gfx_en <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/shram_port.sv
module shram_port
  import shram_pkg::*;
#(
  parameter int          AW         = 24,
  parameter int          WAW        = 6,
  parameter logic        IS_MAIN    = 1'b1,
  parameter logic [23:0] BASE_WHOLE = 24'h200000,
  parameter logic [23:0] BASE_SPLIT = 24'h200000
) (
  input  logic           req,
  input  logic [AW-1:0]  addr,
  input  logic           split,
  input  logic           swap,
  output logic           go,
  output logic           deny,
  output logic           bank,
  output logic [WAW-1:0] word
);

  logic [23:0] a24;
  logic        hit;
  logic        owns;
  logic        unused_addr;

  assign a24         = 24'(addr);
  assign unused_addr = ^addr;
  assign hit  = split ? win_hit(a24, BASE_SPLIT, SPLIT_SPAN)
                      : win_hit(a24, BASE_WHOLE, WHOLE_SPAN);
  assign owns = cpu_owns(IS_MAIN, split, swap);
  assign bank = cpu_bank(IS_MAIN, split, swap, a24[17]);
  assign word = a24[WAW:1];
  assign go   = req && hit && owns;
  assign deny = req && hit && !owns;

endmodule

// File: rtl/shram_bank.sv
module shram_bank #(
  parameter int WAW = 6
) (
  input  logic           clk,
  input  logic           en,
  input  logic           we,
  input  logic [WAW-1:0] addr,
  input  logic [15:0]    wdata,
  output logic [15:0]    rdata
);

  localparam int DEPTH = 1 << WAW;

  logic [15:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end

endmodule

// File: rtl/shram_switch.sv
module shram_switch
  import shram_pkg::*;
#(
  parameter int   WAW    = 6,
  parameter logic REGION = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        main_req,
  input  logic        main_we,
  input  logic [23:0] main_addr,
  input  logic [15:0] main_wdata,
  output logic [15:0] main_rdata,
  output logic        main_viol,
  input  logic        sub_req,
  input  logic        sub_we,
  input  logic [19:0] sub_addr,
  input  logic [15:0] sub_wdata,
  output logic [15:0] sub_rdata,
  output logic        sub_viol,
  input  logic        gfx_start,
  input  logic        gfx_req,
  input  logic        gfx_we,
  input  logic [17:0] gfx_addr,
  input  logic [15:0] gfx_wdata,
  output logic        gfx_gnt,
  output logic [15:0] gfx_rdata,
  input  logic        ctl_we,
  input  logic [7:0]  ctl_wdata,
  output logic [7:0]  ctl_rdata
);

  localparam int NBANK = 2;

  shram_cfg_t     cfg;
  logic           apply_evt;
  logic           cfg_split, cfg_swap, cfg_gfx;
  logic           main_go, main_deny, main_bank;
  logic           sub_go, sub_deny, sub_bank;
  logic [WAW-1:0] main_word, sub_word, gfx_word;
  logic           gfx_bank, gfx_try;
  logic           unused_gfx;
  logic [NBANK-1:0] gfx_sel;
  logic [15:0]    bank_rd [NBANK];

  logic           main_rv_q, sub_rv_q, gfx_rv_q;
  logic           main_bk_q, sub_bk_q, gfx_bk_q;

  shram_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .busy(main_req || sub_req), .gfx_start(gfx_start),
    .cfg(cfg), .apply_evt(apply_evt)
  );

  assign cfg_split = cfg.split;
  assign cfg_swap  = cfg.swap;
  assign cfg_gfx   = cfg.gfx_en;
  assign ctl_rdata = ctl_view(cfg, REGION);

  shram_port #(.AW(24), .WAW(WAW), .IS_MAIN(1'b1),
               .BASE_WHOLE(24'h200000), .BASE_SPLIT(24'h200000)) u_main_port (
    .req(main_req), .addr(main_addr), .split(cfg_split), .swap(cfg_swap),
    .go(main_go), .deny(main_deny), .bank(main_bank), .word(main_word)
  );

  shram_port #(.AW(20), .WAW(WAW), .IS_MAIN(1'b0),
               .BASE_WHOLE(24'h080000), .BASE_SPLIT(24'h0C0000)) u_sub_port (
    .req(sub_req), .addr(sub_addr), .split(cfg_split), .swap(cfg_swap),
    .go(sub_go), .deny(sub_deny), .bank(sub_bank), .word(sub_word)
  );

  assign gfx_try    = gfx_req && cfg_gfx;
  assign gfx_bank   = gfx_addr[17];
  assign gfx_word   = gfx_addr[WAW:1];
  assign unused_gfx = ^gfx_addr;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic           m_sel, s_sel;
    logic           en, we;
    logic [WAW-1:0] addr;
    logic [15:0]    wdata;

    assign m_sel      = main_go && (main_bank == 1'(b));
    assign s_sel      = sub_go  && (sub_bank  == 1'(b));
    assign gfx_sel[b] = gfx_try && (gfx_bank == 1'(b)) && !m_sel && !s_sel;
    assign en    = m_sel || s_sel || gfx_sel[b];
    assign we    = m_sel ? main_we    : s_sel ? sub_we    : gfx_we;
    assign addr  = m_sel ? main_word  : s_sel ? sub_word  : gfx_word;
    assign wdata = m_sel ? main_wdata : s_sel ? sub_wdata : gfx_wdata;

    shram_bank #(.WAW(WAW)) u_bank (
      .clk(clk), .en(en), .we(we), .addr(addr), .wdata(wdata), .rdata(bank_rd[b])
    );
  end

  assign gfx_gnt = |gfx_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      main_rv_q <= 1'b0; sub_rv_q <= 1'b0; gfx_rv_q <= 1'b0;
      main_bk_q <= 1'b0; sub_bk_q <= 1'b0; gfx_bk_q <= 1'b0;
      main_viol <= 1'b0; sub_viol <= 1'b0;
    end else begin
      main_rv_q <= main_go && !main_we;
      sub_rv_q  <= sub_go  && !sub_we;
      gfx_rv_q  <= gfx_gnt && !gfx_we;
      main_bk_q <= main_bank;
      sub_bk_q  <= sub_bank;
      gfx_bk_q  <= gfx_bank;
      main_viol <= main_deny;
      sub_viol  <= sub_deny;
    end
  end

  assign main_rdata = main_rv_q ? bank_rd[main_bk_q] : 16'h0000;
  assign sub_rdata  = sub_rv_q  ? bank_rd[sub_bk_q]  : 16'h0000;
  assign gfx_rdata  = gfx_rv_q  ? bank_rd[gfx_bk_q]  : 16'h0000;

endmodule

// File: rtl/shram_switch_chk.sv
module shram_switch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        main_req,
  input logic        sub_req,
  input logic        main_viol,
  input logic        sub_viol,
  input logic [15:0] main_rdata,
  input logic [15:0] sub_rdata,
  input logic        gfx_req,
  input logic        gfx_gnt,
  input logic        main_go,
  input logic        sub_go,
  input logic        cfg_split,
  input logic        cfg_swap,
  input logic        cfg_gfx
);

  // R4
  main_viol_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    main_viol |-> $past(main_req));

  // R4
  sub_viol_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_viol |-> $past(sub_req));

  // R4
  viol_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (main_viol |-> main_rdata == 16'h0000) and (sub_viol |-> sub_rdata == 16'h0000));

  // R4
  whole_single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_split |-> !(main_go && sub_go));

  // R6
  split_no_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_split) |-> (!main_viol && !sub_viol));

  // R8
  cfg_idle_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_split != $past(cfg_split)) || (cfg_swap != $past(cfg_swap)))
      |-> $past(!main_req && !sub_req));

  // R9
  gfx_gnt_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gfx_gnt |-> (cfg_gfx && gfx_req));

endmodule

bind shram_switch shram_switch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .main_req(main_req), .sub_req(sub_req),
  .main_viol(main_viol), .sub_viol(sub_viol),
  .main_rdata(main_rdata), .sub_rdata(sub_rdata),
  .gfx_req(gfx_req), .gfx_gnt(gfx_gnt),
  .main_go(main_go), .sub_go(sub_go),
  .cfg_split(cfg_split), .cfg_swap(cfg_swap), .cfg_gfx(cfg_gfx)
);

// File: tb/shram_switch_bench.sv
module shram_switch_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        main_req = 0, main_we = 0;
  logic [23:0] main_addr = '0;
  logic [15:0] main_wdata = '0;
  logic [15:0] main_rdata;
  logic        main_viol;
  logic        sub_req = 0, sub_we = 0;
  logic [19:0] sub_addr = '0;
  logic [15:0] sub_wdata = '0;
  logic [15:0] sub_rdata;
  logic        sub_viol;
  logic        gfx_start = 0, gfx_req = 0, gfx_we = 0;
  logic [17:0] gfx_addr = '0;
  logic [15:0] gfx_wdata = '0;
  logic        gfx_gnt;
  logic [15:0] gfx_rdata;
  logic        ctl_we = 0;
  logic [7:0]  ctl_wdata = '0;
  logic [7:0]  ctl_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  shram_switch u_shram_switch (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic main_acc(input logic we, input logic [23:0] a, input logic [15:0] d,
                          output logic [15:0] rd, output logic vi);
    @(negedge clk);
    main_req = 1; main_we = we; main_addr = a; main_wdata = d;
    @(negedge clk);
    main_req = 0; main_we = 0;
    rd = main_rdata; vi = main_viol;
  endtask

  task automatic sub_acc(input logic we, input logic [19:0] a, input logic [15:0] d,
                         output logic [15:0] rd, output logic vi);
    @(negedge clk);
    sub_req = 1; sub_we = we; sub_addr = a; sub_wdata = d;
    @(negedge clk);
    sub_req = 0; sub_we = 0;
    rd = sub_rdata; vi = sub_viol;
  endtask

  task automatic set_ctl(input logic [7:0] v);
    @(negedge clk);
    ctl_we = 1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 reset ctl", 32'(ctl_rdata), 32'h03);
    chk("R1 reset viol", 32'({main_viol, sub_viol}), 32'h0);
  endtask

  task automatic t_whole;
    logic [15:0] rd; logic vi;
    main_acc(1, 24'h20000A, 16'hA111, rd, vi);
    main_acc(1, 24'h22000A, 16'hB222, rd, vi);
    main_acc(0, 24'h20000A, 0, rd, vi);
    chk("R2 main half0", 32'(rd), 32'hA111);
    main_acc(0, 24'h22000A, 0, rd, vi);
    chk("R2 main half1", 32'(rd), 32'hB222);
    chk("R2 no viol", 32'(vi), 32'h0);
    sub_acc(0, 20'h8000A, 0, rd, vi);
    chk("R4 sub refused rdata", 32'(rd), 32'h0);
    chk("R4 sub refused viol", 32'(vi), 32'h1);
    @(negedge clk);
    chk("R4 viol one cycle", 32'(sub_viol), 32'h0);
    set_ctl(8'h00);
    chk("R10 ctl whole sub", 32'(ctl_rdata), 32'h02);
    sub_acc(0, 20'h8000A, 0, rd, vi);
    chk("R3 sub half0", 32'(rd), 32'hA111);
    sub_acc(0, 20'hA000A, 0, rd, vi);
    chk("R3 sub half1", 32'(rd), 32'hB222);
    main_acc(1, 24'h20000A, 16'hDEAD, rd, vi);
    chk("R4 main write refused viol", 32'(vi), 32'h1);
    main_acc(0, 24'h20000A, 0, rd, vi);
    chk("R4 main read refused", 32'({vi, rd}), 32'h1_0000);
    sub_acc(0, 20'h8000A, 0, rd, vi);
    chk("R4 dropped write left data", 32'(rd), 32'hA111);
  endtask

  task automatic t_outside;
    logic [15:0] rd; logic vi;
    sub_acc(1, 20'hC000A, 16'h5555, rd, vi);
    sub_acc(0, 20'hC000A, 0, rd, vi);
    chk("R7 sub outside", 32'({vi, rd}), 32'h0);
    main_acc(0, 24'h30000A, 0, rd, vi);
    chk("R7 main outside", 32'({vi, rd}), 32'h0);
    sub_acc(0, 20'h8000A, 0, rd, vi);
    chk("R7 outside write ignored", 32'(rd), 32'hA111);
  endtask

  task automatic t_split;
    logic [15:0] rd; logic vi;
    set_ctl(8'h05);
    chk("R10 ctl split swap1", 32'(ctl_rdata), 32'h07);
    main_acc(0, 24'h20000A, 0, rd, vi);
    chk("R6 swap1 main half0", 32'({vi, rd}), 32'h0_A111);
    sub_acc(0, 20'hC000A, 0, rd, vi);
    chk("R6 swap1 sub half1", 32'({vi, rd}), 32'h0_B222);
    main_acc(0, 24'h22000A, 0, rd, vi);
    chk("R5 main above split window", 32'({vi, rd}), 32'h0);
    sub_acc(0, 20'h8000A, 0, rd, vi);
    chk("R5 sub old window closed", 32'({vi, rd}), 32'h0);
    set_ctl(8'h06);
    chk("R10 bit1 write ignored", 32'(ctl_rdata), 32'h06);
    main_acc(0, 24'h20000A, 0, rd, vi);
    chk("R6 swap0 main half1", 32'({vi, rd}), 32'h0_B222);
    sub_acc(0, 20'hC000A, 0, rd, vi);
    chk("R6 swap0 sub half0", 32'({vi, rd}), 32'h0_A111);
  endtask

  task automatic t_deferred;
    @(negedge clk);
    main_req = 1; main_we = 0; main_addr = 24'h20000A;
    ctl_we = 1; ctl_wdata = 8'h05;
    @(negedge clk);
    ctl_we = 0;
    chk("R8 old map held 1", 32'(main_rdata), 32'hB222);
    chk("R8 ctl not yet 1", 32'(ctl_rdata), 32'h06);
    @(negedge clk);
    chk("R8 old map held 2", 32'(main_rdata), 32'hB222);
    chk("R8 ctl not yet 2", 32'(ctl_rdata), 32'h06);
    main_req = 0;
    @(negedge clk);
    chk("R8 applied after idle", 32'(ctl_rdata), 32'h07);
  endtask

  task automatic t_gfx;
    @(negedge clk);
    gfx_req = 1; gfx_we = 0; gfx_addr = 18'h0000A;
    #1 chk("R9 no grant while disabled", 32'(gfx_gnt), 32'h0);
    gfx_req = 0;
    @(negedge clk);
    gfx_start = 1;
    @(negedge clk);
    gfx_start = 0;
    chk("R9 start sets enable", 32'(ctl_rdata), 32'h0F);
    gfx_req = 1; gfx_addr = 18'h0000A;
    #1 chk("R9 grant half0", 32'(gfx_gnt), 32'h1);
    @(negedge clk);
    chk("R9 read half0", 32'(gfx_rdata), 32'hA111);
    gfx_addr = 18'h2000A;
    @(negedge clk);
    chk("R9 read half1", 32'(gfx_rdata), 32'hB222);
    gfx_addr = 18'h0000A; main_req = 1; main_addr = 24'h20000A;
    #1 chk("R9 cpu wins same half", 32'(gfx_gnt), 32'h0);
    @(negedge clk);
    chk("R9 cpu data intact", 32'(main_rdata), 32'hA111);
    gfx_addr = 18'h2000A;
    #1 chk("R9 other half granted", 32'(gfx_gnt), 32'h1);
    @(negedge clk);
    main_req = 0; gfx_req = 0;
    chk("R9 other half data", 32'(gfx_rdata), 32'hB222);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_whole();
    t_outside();
    t_split();
    t_deferred();
    t_gfx();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule